// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two parallel buses, called A and B, through a pair of storage registers, one for each direction. Each side can be driven by the block, driven from outside or left floating. When the block drives a side, that side receives either the live value of the opposite bus or the value held in that direction's register. The two registers capture their own bus on every cycle in which their capture strobe is high, whatever the enables and selects are doing. This gives isolation, live transfer in either direction, capture of one or both buses, and replay of stored data to one or both buses.

Each bus is modelled inside the block by a resolver. The block's own driver has priority. If the block is not driving, an external source may drive the bus. If neither drives it, a bus-hold register keeps the last resolved value. The two enables have opposite polarities. The live/stored selects are retimed through flops, so the multiplexer control changes only at clock edges. When both sides are enabled and both selects are live, each bus feeds the other. This loop is closed through the hold registers, so each bus keeps its own value and the design has no combinational path around the loop.

Top module: `bus_xcvr_reg`

## Requirements
- R1: An asynchronous active-low reset clears both storage registers, both hold registers and both select flops to zero. After reset an undriven bus reads zero.
- R2: On each rising clock edge with `cap_a` high, the A register loads the resolved A bus. With `cap_b` high, the B register loads the resolved B bus. Enables and selects have no effect on capture.
- R3: `en_ab` high makes the block drive B (`b_oe`=1). `en_ba_n` low makes it drive A (`a_oe`=1). With `en_ab`=0 and `en_ba_n`=1 neither side is driven by the block.
- R4: A select of 1 drives the stored register onto the target side: the A register onto B for `sel_ab`, and the B register onto A for `sel_ba`. With both enables active and both selects at 1, both replays happen at the same time.
- R5: A select of 0 forwards the live value of the opposite bus to the driven side in the same cycle.
- R6: A change on a select takes effect only after the next clock edge. In the cycle of the change, the driven bus still shows the previously selected source.
- R7: While one side forwards live data from the other, a capture on the driven side stores the forwarded value, so one bus's data can be written into both registers.
- R8: Captures in the same cycle both sample pre-edge bus values. With a stored select, a same-cycle capture on the driven side loads the other register's old content, so a new value needs staggered strobes to reach both registers.
- R9: With both sides enabled and both selects live, each bus holds its last value, and the external inputs on both sides are ignored.
- R10: A bus that neither the block nor an external source drives keeps its last resolved value.
- R11: When the block drives a side, that side's external input is ignored. Otherwise an asserted external drive strobe places the external value on the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_ab | input | 1 | Drive B bus from the block, active high |
| en_ba_n | input | 1 | Drive A bus from the block, active low |
| sel_ab | input | 1 | Source for B: 0 live A bus, 1 A register |
| sel_ba | input | 1 | Source for A: 0 live B bus, 1 B register |
| cap_a | input | 1 | Capture strobe for the A register |
| cap_b | input | 1 | Capture strobe for the B register |
| a_in | input | W | External value on the A bus |
| a_drv | input | 1 | External source drives the A bus |
| b_in | input | W | External value on the B bus |
| b_drv | input | 1 | External source drives the B bus |
| a_out | output | W | Value the block offers to the A bus |
| a_oe | output | 1 | Block drives the A bus |
| b_out | output | W | Value the block offers to the B bus |
| b_oe | output | 1 | Block drives the B bus |
| a_bus | output | W | Resolved A bus |
| b_bus | output | W | Resolved B bus |

## Verification
The bench builds the block with a 4-bit data width. At that width, arithmetic data patterns reach every code on both buses within a short run. It sweeps all 64 combinations of the six control inputs, each under four external-drive patterns, against a cycle model that carries its own registers, hold state and retimed selects. Directed sequences come first and reach the cases a sweep hits only by chance: the select lag, both loads from one bus, staggered versus same-cycle loads, and the self-holding loop under changing external inputs.

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_ab,
  input  logic         en_ba_n,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         cap_a,
  input  logic         cap_b,
  input  logic [W-1:0] a_in,
  input  logic         a_drv,
  input  logic [W-1:0] b_in,
  input  logic         b_drv,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  output logic [W-1:0] a_bus,
  output logic [W-1:0] b_bus
);

  logic [W-1:0] reg_a, reg_b, hold_a, hold_b;
  logic [W-1:0] ext_a, ext_b;
  logic         sab_q, sba_q, run_q;
  logic         loop;

  assign a_oe = !en_ba_n;
  assign b_oe = en_ab;
  assign loop = a_oe && b_oe && !sab_q && !sba_q;

  assign ext_a = a_drv ? a_in : hold_a;
  assign ext_b = b_drv ? b_in : hold_b;

  assign a_out = loop  ? hold_a :
                 sba_q ? reg_b  :
                 !b_oe ? ext_b  :
                 sab_q ? reg_a  : ext_a;

  assign b_out = loop  ? hold_b :
                 sab_q ? reg_a  :
                 !a_oe ? ext_a  :
                 sba_q ? reg_b  : ext_b;

  assign a_bus = a_oe ? a_out : ext_a;
  assign b_bus = b_oe ? b_out : ext_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sab_q <= 1'b0;
      sba_q <= 1'b0;
      run_q <= 1'b0;
    end else begin
      sab_q <= sel_ab;
      sba_q <= sel_ba;
      run_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_a <= '0;
      reg_b <= '0;
    end else begin
      if (cap_a) reg_a <= a_bus;
      if (cap_b) reg_b <= b_bus;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_a <= '0;
      hold_b <= '0;
    end else begin
      hold_a <= a_bus;
      hold_b <= b_bus;
    end
  end

  AST_CAPTURE_A: assert property (@(posedge clk) disable iff (!rst_n)
    cap_a |=> reg_a == $past(a_bus)); // R2
  AST_CAPTURE_B: assert property (@(posedge clk) disable iff (!rst_n)
    cap_b |=> reg_b == $past(b_bus)); // R2
  AST_STORED_TO_B: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && b_oe && $past(sel_ab) |-> b_bus == reg_a); // R4
  AST_STORED_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && a_oe && $past(sel_ba) |-> a_bus == reg_b); // R4
  AST_LIVE_TO_B: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && b_oe && !a_oe && !$past(sel_ab) |-> b_bus == a_bus); // R5
  AST_LIVE_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && a_oe && !b_oe && !$past(sel_ba) |-> a_bus == b_bus); // R5
  AST_LOOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && loop && $past(loop) |-> $stable(a_bus) && $stable(b_bus)); // R9
  AST_FLOAT_A: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && !a_oe && !a_drv |-> a_bus == $past(a_bus)); // R10
  AST_FLOAT_B: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && !b_oe && !b_drv |-> b_bus == $past(b_bus)); // R10

endmodule

// File: tb/bus_xcvr_reg_test.sv
`timescale 1ns/1ps
module bus_xcvr_reg_test;
  localparam int BW = 4;
  localparam int LIMIT = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_ab = 0, en_ba_n = 1, sel_ab = 0, sel_ba = 0, cap_a = 0, cap_b = 0;
  logic [BW-1:0] a_in = '0, b_in = '0;
  logic a_drv = 0, b_drv = 0;
  logic [BW-1:0] a_out, b_out, a_bus, b_bus;
  logic a_oe, b_oe;

  logic [BW-1:0] m_ra = '0, m_rb = '0, m_ha = '0, m_hb = '0;
  logic m_sab = 0, m_sba = 0;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  bus_xcvr_reg #(.W(BW)) uut (
    .clk(clk), .rst_n(rst_n), .en_ab(en_ab), .en_ba_n(en_ba_n),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_a(cap_a), .cap_b(cap_b),
    .a_in(a_in), .a_drv(a_drv), .b_in(b_in), .b_drv(b_drv),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
    .a_bus(a_bus), .b_bus(b_bus));

  task automatic step(input logic eab, input logic ebn, input logic sab, input logic sba,
                      input logic ca, input logic cb,
                      input logic [BW-1:0] ai, input logic ad,
                      input logic [BW-1:0] bi, input logic bd, input string tag);
    logic [BW-1:0] xa, xb, ea, eb;
    logic oa, ob;
    @(negedge clk);
    en_ab = eab; en_ba_n = ebn; sel_ab = sab; sel_ba = sba;
    cap_a = ca; cap_b = cb; a_in = ai; a_drv = ad; b_in = bi; b_drv = bd;
    #1;
    oa = !ebn; ob = eab;
    xa = ad ? ai : m_ha;
    xb = bd ? bi : m_hb;
    if (!oa && !ob) begin ea = xa; eb = xb; end
    else if (oa && !ob) begin eb = xb; ea = m_sba ? m_rb : eb; end
    else if (!oa && ob) begin ea = xa; eb = m_sab ? m_ra : ea; end
    else if (!m_sab && !m_sba) begin ea = m_ha; eb = m_hb; end
    else if (m_sab && m_sba) begin ea = m_rb; eb = m_ra; end
    else if (m_sab) begin eb = m_ra; ea = eb; end
    else begin ea = m_rb; eb = ea; end
    checks++;
    if (a_bus !== ea || b_bus !== eb || a_oe !== oa || b_oe !== ob) begin
      fails++;
      $display("FAIL %s: a_bus=%h b_bus=%h a_oe=%b b_oe=%b expected %h %h %b %b",
               tag, a_bus, b_bus, a_oe, b_oe, ea, eb, oa, ob);
    end
    if (ca) m_ra = ea;
    if (cb) m_rb = eb;
    m_ha = ea; m_hb = eb;
    m_sab = sab; m_sba = sba;
  endtask

  initial begin
    #(20 * LIMIT);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #35 rst_n = 1'b1;
    // R1: reset state, floating buses read zero, replay of cleared registers
    step(0,1,0,0,0,0, 4'h0,0, 4'h0,0, "R1 reset");
    step(1,0,1,1,0,0, 4'h7,1, 4'h9,1, "R1 loop after reset");
    step(1,0,1,1,0,0, 4'h7,1, 4'h9,1, "R1 cleared replay");
    // R3: isolation, external drives visible
    step(0,1,0,0,0,0, 4'h5,1, 4'h9,1, "R3 isolation");
    // R11 and R7: live A->B overrides external B, capture into B
    step(1,1,0,0,0,0, 4'h6,1, 4'h3,1, "R11 drive wins");
    step(1,1,0,0,0,1, 4'h6,1, 4'h3,1, "R7 store A into B");
    step(1,1,0,0,1,0, 4'h6,1, 4'h3,1, "R7 store A into A");
    // R10: nothing drives, buses keep value
    step(0,1,0,0,0,0, 4'h1,0, 4'h2,0, "R10 bus hold");
    step(0,1,0,0,0,0, 4'hF,0, 4'hE,0, "R10 bus hold");
    // R8: same-cycle capture of both, then R4 dual replay
    step(0,1,0,0,1,1, 4'hA,1, 4'h3,1, "R8 same cycle live");
    step(1,0,1,1,0,0, 4'h0,1, 4'h0,1, "R6 select lag");
    step(1,0,1,1,0,0, 4'h0,1, 4'h0,1, "R4 dual replay");
    // R6: stored -> live switch appears one cycle later
    step(1,1,1,0,0,0, 4'hC,1, 4'h0,0, "R4 stored A to B");
    step(1,1,0,0,0,0, 4'hC,1, 4'h0,0, "R6 old source kept");
    step(1,1,0,0,0,0, 4'hC,1, 4'h0,0, "R6 new source live");
    // R9: loop holds, external inputs ignored
    step(1,0,0,0,0,0, 4'h4,1, 4'h8,1, "R9 loop");
    step(1,0,0,0,0,0, 4'hB,1, 4'h2,1, "R9 loop ignore");
    step(1,0,0,0,0,0, 4'h1,0, 4'h6,1, "R9 loop ignore");
    // R8: stored select, same-cycle loads take old A register into B
    step(1,1,1,0,0,0, 4'h5,1, 4'h0,0, "R8 prep");
    step(1,1,1,0,1,1, 4'h5,1, 4'h0,0, "R8 same cycle stored");
    step(1,1,1,0,0,1, 4'h5,1, 4'h0,0, "R8 staggered");
    step(1,0,1,1,0,0, 4'h0,0, 4'h0,0, "R4 replay check");
    step(1,0,1,1,0,0, 4'h0,0, 4'h0,0, "R4 replay check");
    // R2, R3, R4, R5: exhaustive control sweep
    for (int c = 0; c < 64; c++) begin
      for (int p = 0; p < 4; p++) begin
        step(c[0], c[1], c[2], c[3], c[4], c[5],
             BW'(c * 3 + p * 5), p[0], BW'(c * 7 + p * 11 + 1), p[1], "R2 R5 sweep");
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule